// File: doc/BRIEF.md
# USB Control Endpoint Handshake Responder

This block picks the handshake that a USB device returns on its control endpoint and keeps the status flags that firmware polls for that endpoint. Every decoded token (SETUP, OUT or IN) arrives as a one-cycle strobe. It comes with a flag that says whether the data packet that followed was received intact, and with a retry request from the transaction layer. One clock later the block presents a handshake code and updates its flags.

The endpoint has one bank. The bank holds received data while the setup-received or out-received flag is set. It holds IN data between the moment firmware clears the in-ready flag and the moment the packet goes out. Firmware can request a stall. The stall then sticks to every data and status transaction until the next SETUP arrives. A SETUP is always accepted and clears the stall request.

Top module: `usb_ctl_ep_hs`

## Requirements
- R1: A SETUP token (`tok_type` = 2'b11) with `pkt_ok` high is answered one cycle later with `hs_valid` high and `hs_code` = ACK (2'b01). This holds whatever the stall request, the bank occupancy and `retry_req` are.
- R2: An accepted SETUP sets `rxstp_flag` and clears `stall_req` on the same edge. It leaves `rxout_flag` unchanged. A firmware stall request in that same cycle loses to the SETUP.
- R3: Once `fw_set_stall` has set `stall_req`, an OUT token (2'b01) with `pkt_ok` high or an IN token (2'b10) is answered with STALL (2'b11) as long as `retry_req` is low.
- R4: With `retry_req` high, an OUT token with `pkt_ok` high or an IN token is answered with NAK (2'b10), even while `stall_req` is set.
- R5: An OUT token with `pkt_ok` high is answered with ACK and sets `rxout_flag` when it is neither stalled nor retried and both `rxstp_flag` and `rxout_flag` are clear.
- R6: An OUT token that arrives while `rxstp_flag` or `rxout_flag` is set, and that is neither stalled nor retried, is answered with NAK. Its data is dropped and the flags stay unchanged.
- R7: An IN token is answered with NAK, and `nakin_flag` is set, when `txin_flag` is set and the token is not stalled. A retry NAK on an IN token also sets `nakin_flag`.
- R8: An IN token that arrives while `txin_flag` is clear, and that is neither stalled nor retried, gives `hs_valid` high with `hs_code` = NONE (2'b00), because the loaded data is sent instead of a handshake. It also sets `txin_flag` again.
- R9: A firmware clear (`fw_clr_rxstp`, `fw_clr_rxout`, `fw_clr_txin`, `fw_clr_nakin`) takes effect on the next clock edge. When a hardware event sets the same flag in the same cycle, the set wins.
- R10: `bank_ctl` and `rw_allowed` always read 0.
- R11: A SETUP or OUT token with `pkt_ok` low, a token with `tok_type` = 2'b00, and a cycle with no token all leave `hs_valid` low and change no flag.
- R12: After reset, `txin_flag` is 1, the other flags and `stall_req` are 0, and `hs_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-cycle strobe: a token was decoded |
| tok_type | input | 2 | 01 OUT, 10 IN, 11 SETUP, 00 reserved |
| pkt_ok | input | 1 | The data packet after SETUP/OUT was received intact |
| retry_req | input | 1 | The transaction layer asks for a retry |
| fw_set_stall | input | 1 | Firmware sets the stall request |
| fw_clr_rxstp | input | 1 | Firmware clears the setup-received flag |
| fw_clr_rxout | input | 1 | Firmware clears the out-received flag |
| fw_clr_txin | input | 1 | Firmware clears the in-ready flag (data loaded) |
| fw_clr_nakin | input | 1 | Firmware clears the IN-NAK flag |
| hs_valid | output | 1 | Handshake decision is valid this cycle |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| rxstp_flag | output | 1 | A SETUP was received |
| rxout_flag | output | 1 | OUT data was received |
| txin_flag | output | 1 | The bank can take a new IN packet |
| nakin_flag | output | 1 | An IN token was answered with NAK |
| stall_req | output | 1 | The stall request is active |
| bank_ctl | output | 1 | Unused bank-control field, always 0 |
| rw_allowed | output | 1 | Unused read/write-allowed field, always 0 |

## Verification
The bench sends a SETUP while the stall request is set and a retry is pending. A design that let stall or retry override it would return STALL or NAK, and the host could never recover the endpoint. It checks that retry beats stall on both OUT and IN: swapping that priority gives STALL where NAK is expected. It also raises firmware requests in the same cycle as hardware events (a set-stall beside a SETUP, a flag clear beside an OUT or IN) to catch a design that lets the write win. An OUT that arrives while the setup flag is still set must be NAKed without setting the out flag. A design that looked only at the out flag would ACK it and overwrite the setup data.

// File: rtl/usb_ctl_ep_hs.sv
module usb_ctl_ep_hs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_type,
  input  logic       pkt_ok,
  input  logic       retry_req,
  input  logic       fw_set_stall,
  input  logic       fw_clr_rxstp,
  input  logic       fw_clr_rxout,
  input  logic       fw_clr_txin,
  input  logic       fw_clr_nakin,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  output logic       rxstp_flag,
  output logic       rxout_flag,
  output logic       txin_flag,
  output logic       nakin_flag,
  output logic       stall_req,
  output logic       bank_ctl,
  output logic       rw_allowed
);

  localparam logic [1:0] TK_OUT = 2'b01, TK_IN = 2'b10, TK_SETUP = 2'b11;
  localparam logic [1:0] HS_NONE = 2'b00, HS_ACK = 2'b01, HS_NAK = 2'b10, HS_STALL = 2'b11;

  logic is_setup, is_out, is_in;
  assign is_setup = tok_valid && tok_type == TK_SETUP && pkt_ok;
  assign is_out   = tok_valid && tok_type == TK_OUT && pkt_ok;
  assign is_in    = tok_valid && tok_type == TK_IN;

  logic out_busy;
  assign out_busy = rxstp_flag | rxout_flag;

  logic       resp_v;
  logic [1:0] resp;
  logic       set_rxout, set_txin, set_nakin;

  always_comb begin
    resp_v    = 1'b0;
    resp      = HS_NONE;
    set_rxout = 1'b0;
    set_txin  = 1'b0;
    set_nakin = 1'b0;
    if (is_setup) begin
      resp_v = 1'b1;
      resp   = HS_ACK;
    end else if (is_out) begin
      resp_v = 1'b1;
      if (retry_req)      resp = HS_NAK;
      else if (stall_req) resp = HS_STALL;
      else if (out_busy)  resp = HS_NAK;
      else begin
        resp      = HS_ACK;
        set_rxout = 1'b1;
      end
    end else if (is_in) begin
      resp_v = 1'b1;
      if (retry_req) begin
        resp      = HS_NAK;
        set_nakin = 1'b1;
      end else if (stall_req) resp = HS_STALL;
      else if (txin_flag) begin
        resp      = HS_NAK;
        set_nakin = 1'b1;
      end else begin
        resp     = HS_NONE;
        set_txin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid   <= 1'b0;
      hs_code    <= HS_NONE;
      rxstp_flag <= 1'b0;
      rxout_flag <= 1'b0;
      txin_flag  <= 1'b1;
      nakin_flag <= 1'b0;
      stall_req  <= 1'b0;
    end else begin
      hs_valid   <= resp_v;
      hs_code    <= resp;
      rxstp_flag <= is_setup  | (rxstp_flag & ~fw_clr_rxstp);
      rxout_flag <= set_rxout | (rxout_flag & ~fw_clr_rxout);
      txin_flag  <= set_txin  | (txin_flag  & ~fw_clr_txin);
      nakin_flag <= set_nakin | (nakin_flag & ~fw_clr_nakin);
      stall_req  <= ~is_setup & (stall_req | fw_set_stall);
    end
  end

  assign bank_ctl   = 1'b0;
  assign rw_allowed = 1'b0;

  p_setup_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_setup |=> hs_valid && hs_code == HS_ACK);

  p_setup_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_setup && !fw_clr_rxout |=> rxstp_flag && !stall_req && rxout_flag == $past(rxout_flag));

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out || is_in) && stall_req && !retry_req |=> hs_code == HS_STALL);

  p_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out || is_in) && retry_req |=> hs_valid && hs_code == HS_NAK);

  p_out_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_out && !retry_req && !stall_req && rxstp_flag && !fw_clr_rxstp |=> hs_code == HS_NAK && $stable(rxout_flag));

  p_in_nak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_in && !stall_req && txin_flag |=> hs_code == HS_NAK && nakin_flag);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_setup || is_out || is_in) |=> !hs_valid);

endmodule

// File: tb/sim_usb_ctl_ep_hs.sv
module sim_usb_ctl_ep_hs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tok_valid, pkt_ok, retry_req, fw_set_stall;
  logic fw_clr_rxstp, fw_clr_rxout, fw_clr_txin, fw_clr_nakin;
  logic [1:0] tok_type, hs_code;
  logic hs_valid, rxstp_flag, rxout_flag, txin_flag, nakin_flag, stall_req, bank_ctl, rw_allowed;

  usb_ctl_ep_hs u0 (.*);

  int n_chk = 0, n_bad = 0;

  // {valid,type[1:0],ok,retry,set_stall,clr{stp,out,txin,nak}, exp_hv,exp_code[1:0], exp{stp,out,txin,nak,stall}}
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    18'b1_01_1_0_0_0000_1_01_01100, // R5 OUT accepted
    18'b1_01_1_0_0_0000_1_10_01100, // R6 OUT while rxout set
    18'b0_00_0_0_0_0100_0_00_00100, // R9 clear rxout
    18'b1_10_0_0_0_0000_1_10_00110, // R7 IN with txin set
    18'b0_00_0_0_0_0011_0_00_00000, // R9 load IN, clear nakin
    18'b1_10_0_0_0_0000_1_00_00100, // R8 IN sends data
    18'b0_00_0_0_1_0000_0_00_00101, // R3 set stall
    18'b1_01_1_0_0_0000_1_11_00101, // R3 OUT stalled
    18'b1_10_0_0_0_0000_1_11_00101, // R3 IN stalled
    18'b1_01_1_1_0_0000_1_10_00101, // R4 OUT retry over stall
    18'b1_10_0_1_0_0000_1_10_00111, // R4 R7 IN retry over stall
    18'b1_11_1_1_0_0000_1_01_10110, // R1 R2 SETUP clears stall
    18'b1_01_1_0_0_0000_1_10_10110, // R6 OUT while rxstp set
    18'b1_11_0_0_0_0000_0_00_10110, // R11 bad SETUP
    18'b0_00_0_0_0_1001_0_00_00100, // R9 clear rxstp, nakin
    18'b1_01_0_0_0_0000_0_00_00100, // R11 bad OUT
    18'b1_11_1_0_1_0000_1_01_10100, // R2 SETUP beats set_stall
    18'b0_00_0_0_0_1000_0_00_00100, // R9 clear rxstp
    18'b1_01_1_0_0_0100_1_01_01100, // R9 set beats clear rxout
    18'b1_10_0_0_0_0001_1_10_01110, // R9 set beats clear nakin
    18'b1_11_1_0_0_0000_1_01_11110, // R2 SETUP keeps rxout
    18'b1_00_1_0_0_0000_0_00_11110  // R11 reserved token
  };

  task automatic idle();
    tok_valid = 0; tok_type = 0; pkt_ok = 0; retry_req = 0; fw_set_stall = 0;
    fw_clr_rxstp = 0; fw_clr_rxout = 0; fw_clr_txin = 0; fw_clr_nakin = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk("R12", {hs_valid, hs_code, rxstp_flag, rxout_flag, txin_flag, nakin_flag, stall_req}, 8'b0_00_00100);
    chk("R10", {6'd0, bank_ctl, rw_allowed}, 8'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_reset();
    for (int i = 0; i < NV; i++) begin
      {tok_valid, tok_type, pkt_ok, retry_req, fw_set_stall,
       fw_clr_rxstp, fw_clr_rxout, fw_clr_txin, fw_clr_nakin} = VEC[i][17:8];
      @(negedge clk);
      idle();
      chk($sformatf("R1-vec%0d", i),
          {hs_valid, hs_code, rxstp_flag, rxout_flag, txin_flag, nakin_flag, stall_req}, VEC[i][7:0]);
      chk("R10", {6'd0, bank_ctl, rw_allowed}, 8'd0);
    end
    // R11 idle cycle leaves everything alone
    @(negedge clk);
    chk("R11", {hs_valid, hs_code, rxstp_flag, rxout_flag, txin_flag, nakin_flag, stall_req}, 8'b0_00_11110);
    // R1 SETUP while stalled, bank full, retry pending
    fw_set_stall = 1;
    @(negedge clk);
    idle();
    tok_valid = 1; tok_type = 2'b11; pkt_ok = 1; retry_req = 1;
    @(negedge clk);
    idle();
    chk("R1", {hs_valid, hs_code, 5'd0}, 8'b1_01_00000);
    chk("R2", {7'd0, stall_req}, 8'd0);
    // R12 reset again mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule